// File: doc/BRIEF.md
# Serial Control Slave with Queued Interrupt Reporting

This block lets a host processor reach a small bank of 8-bit control registers through a three-wire synchronous serial link, and lets the chip raise interrupts that the host collects over the same link. Each transfer is one 16-bit word, framed by an active-low select. Incoming data arrives on the serial data input, and the reply leaves on the serial data output. A mode input chooses which serial clock edge captures data; the opposite edge launches the reply. The serial clock need not be related to the system clock. The block samples the serial pins in the system clock domain after a synchronizer and finds the clock edges there, so every state change, including completed register writes, takes place on the system clock.

Interrupt events from the chip enter a small first-in-first-out queue. While the queue holds anything and no transfer is running, the block drives its open-drain interrupt request. The request is released as soon as a transfer starts. The word the host receives during that transfer is the oldest queued event, tagged by a set top bit. If events remain after the transfer, the request returns once the select is raised. When no event is waiting, the reply is a readback of the register addressed by the last good transfer. A transfer that does not contain exactly 16 capture edges leaves no trace.

Top module: `mw_ctl_slave`

## Requirements
- R1: A good transfer whose word has bit 15 set writes bits 7:0 into the register selected by bits 14:8. It then gives one `wr_stb_o` pulse carrying that address and data. Bits are sent most significant first. No pulse follows a transfer with bit 15 clear.
- R2: With `edge_sel_i` = 0, data is captured on the rising serial clock edge and the reply advances on the falling edge, with the clock idle low. With `edge_sel_i` = 1, both edges and the idle level are reversed. The first reply bit is present before the first capture edge.
- R3: `sdo_oe_o` is high only while `scs_n_i` is low. When it is low, the output driver is off (high impedance).
- R4: A transfer that ends with a capture count other than 16 writes nothing, pops nothing and leaves the readback pointer unchanged.
- R5: If the queue is empty when the select falls, the reply is {1'b0, pointer[6:0], register[pointer]}. The pointer is the address field of the last good transfer. Addresses at or above `REG_COUNT` read as zero and their writes are dropped with no strobe.
- R6: If the queue is not empty when the select falls, the reply is {1'b1, oldest event[14:0]}. That entry is removed only if the transfer is good.
- R7: `irq_pull_o` is high while the queue is not empty and no transfer is running. It is low during a transfer, and it returns after the select rises if entries remain.
- R8: The queue keeps events in arrival order and holds `Q_DEPTH` (4) entries. An event that arrives while the queue is full is dropped and sets `evt_ovf_o`, which stays set until reset.
- R9: After reset, all registers and the pointer are zero, the queue is empty, and `irq_pull_o`, `evt_ovf_o` and `wr_stb_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| edge_sel_i | input | 1 | Capture edge select: 0 rising, 1 falling |
| sclk_i | input | 1 | Serial clock from the host |
| scs_n_i | input | 1 | Active-low transfer select |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial reply data |
| sdo_oe_o | output | 1 | Reply driver enable (low = high impedance) |
| evt_push_i | input | 1 | Interrupt event strobe |
| evt_word_i | input | 15 | Interrupt event payload |
| irq_pull_o | output | 1 | Open-drain request: 1 pulls the line low |
| evt_ovf_o | output | 1 | Sticky event-drop flag |
| wr_stb_o | output | 1 | One-cycle completed-write strobe |
| wr_addr_o | output | 7 | Address of the completed write |
| wr_data_o | output | 8 | Data of the completed write |

## Verification
The assertions assume that the serial pins are slow next to the system clock. Each serial clock half-period must span more than the synchronizer depth plus one cycle. They also assume that `edge_sel_i` and the serial clock idle level change only while the select is high, and that a select edge never lands in the same sampled cycle as a serial clock edge. The stimulus holds every serial level for eight system cycles. It sets the mode and the idle level several cycles before lowering the select, and it raises the select half a period after the last launch edge. Events are pushed only between transfers, so the reply expected at each select fall is fixed when the transfer begins.

// File: rtl/mw_ctl_pkg.sv
package mw_ctl_pkg;

    localparam int FRAME_W = 16;
    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 8;
    localparam int EVT_W   = FRAME_W - 1;
    localparam int CNT_W   = $clog2(FRAME_W + 2);

    typedef enum logic {
        CAP_RISE = 1'b0,
        CAP_FALL = 1'b1
    } cap_edge_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_t;

    typedef struct packed {
        logic             is_evt;
        logic [EVT_W-1:0] body;
    } reply_t;

    function automatic reply_t make_reply(
        input logic              have_evt,
        input logic [EVT_W-1:0]  evt,
        input logic [ADDR_W-1:0] ptr,
        input logic [DATA_W-1:0] rdata
    );
        reply_t r;
        r.is_evt = have_evt;
        r.body   = have_evt ? evt : {ptr, rdata};
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
        return (c == CNT_W'(FRAME_W + 1)) ? c : c + 1'b1;
    endfunction

    function automatic logic addr_ok(input logic [ADDR_W-1:0] a, input int unsigned n);
        return {{(32-ADDR_W){1'b0}}, a} < n;
    endfunction

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
        end else begin
            chain[0] <= d_i;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/mw_frame_engine.sv
module mw_frame_engine
    import mw_ctl_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  cap_edge_e cap_sel_i,
    input  logic      sclk_s_i,
    input  logic      scs_n_s_i,
    input  logic      sdi_s_i,
    input  reply_t    reply_i,
    output logic      load_o,
    output logic      sdo_o,
    output logic      active_o,
    output logic      frame_end_o,
    output logic      frame_ok_o,
    output cmd_t      cmd_o
);
    logic               sclk_d, scs_d, active;
    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-1:0] rx, tx;
    logic rise, fall, cs_fall, cs_rise, cap, lau;

    always_comb begin
        rise    = !sclk_d && sclk_s_i;
        fall    = sclk_d && !sclk_s_i;
        cs_fall = scs_d && !scs_n_s_i;
        cs_rise = !scs_d && scs_n_s_i;
        cap     = (cap_sel_i == CAP_FALL) ? fall : rise;
        lau     = (cap_sel_i == CAP_FALL) ? rise : fall;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sclk_d <= 1'b0;
            scs_d  <= 1'b1;
            active <= 1'b0;
            cnt    <= '0;
            rx     <= '0;
            tx     <= '0;
        end else begin
            sclk_d <= sclk_s_i;
            scs_d  <= scs_n_s_i;
            if (cs_fall) begin
                active <= 1'b1;
                cnt    <= '0;
                rx     <= '0;
                tx     <= reply_i;
            end else if (cs_rise) begin
                active <= 1'b0;
            end else if (active) begin
                if (cap) begin
                    rx  <= {rx[FRAME_W-2:0], sdi_s_i};
                    cnt <= sat_inc(cnt);
                end
                if (lau) tx <= {tx[FRAME_W-2:0], 1'b0};
            end
        end
    end

    assign load_o      = cs_fall;
    assign sdo_o       = tx[FRAME_W-1];
    assign active_o    = active;
    assign frame_end_o = cs_rise && active;
    assign frame_ok_o  = cs_rise && active && (cnt == CNT_W'(FRAME_W));
    assign cmd_o       = cmd_t'(rx);
endmodule

// File: rtl/mw_irq_fifo.sv
module mw_irq_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 15,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          push_i,
    input  logic [W-1:0]  push_data_i,
    input  logic          pop_i,
    output logic [W-1:0]  head_o,
    output logic [CW-1:0] count_o,
    output logic          drop_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          accept, pop_ok;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        pop_ok = pop_i && (count != '0);
        accept = push_i && ((count != CW'(DEPTH)) || pop_ok);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (accept) begin
                mem[wr_ptr] <= push_data_i;
                wr_ptr      <= wrap_inc(wr_ptr);
            end
            if (pop_ok) rd_ptr <= wrap_inc(rd_ptr);
            case ({accept, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head_o  = mem[rd_ptr];
    assign count_o = count;
    assign drop_o  = push_i && !accept;
endmodule

// File: rtl/mw_reg_bank.sv
module mw_reg_bank
    import mw_ctl_pkg::*;
#(
    parameter int REG_COUNT = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int IDX_W = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;

    logic [DATA_W-1:0] regs [REG_COUNT];

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk_i) begin
            if (rst_i) q <= '0;
            else if (wr_en_i && wr_addr_i == ADDR_W'(g)) q <= wr_data_i;
        end
        assign regs[g] = q;
    end

    assign rd_data_o = addr_ok(rd_addr_i, REG_COUNT) ? regs[rd_addr_i[IDX_W-1:0]] : '0;
endmodule

// File: rtl/mw_ctl_slave.sv
module mw_ctl_slave
    import mw_ctl_pkg::*;
#(
    parameter int REG_COUNT   = 16,
    parameter int Q_DEPTH     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              edge_sel_i,
    input  logic              sclk_i,
    input  logic              scs_n_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    input  logic              evt_push_i,
    input  logic [EVT_W-1:0]  evt_word_i,
    output logic              irq_pull_o,
    output logic              evt_ovf_o,
    output logic              wr_stb_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o
);
    localparam int Q_CW = $clog2(Q_DEPTH + 1);

    logic              sclk_s, scs_n_s, sdi_s;
    logic              load, xfer_active, frame_end, frame_ok;
    cmd_t              cmd;
    reply_t            reply;
    logic [EVT_W-1:0]  q_head;
    logic [Q_CW-1:0]   q_count;
    logic              q_drop, q_pop;
    logic              sent_evt;
    logic [ADDR_W-1:0] rd_ptr;
    logic [DATA_W-1:0] rd_data;
    logic              irq_q, ovf_q, stb_q;
    logic [ADDR_W-1:0] stb_addr_q;
    logic [DATA_W-1:0] stb_data_q;

    mw_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   ({sclk_i, scs_n_i, sdi_i}),
        .q_o   ({sclk_s, scs_n_s, sdi_s})
    );

    mw_frame_engine u_frame (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .cap_sel_i   (cap_edge_e'(edge_sel_i)),
        .sclk_s_i    (sclk_s),
        .scs_n_s_i   (scs_n_s),
        .sdi_s_i     (sdi_s),
        .reply_i     (reply),
        .load_o      (load),
        .sdo_o       (sdo_o),
        .active_o    (xfer_active),
        .frame_end_o (frame_end),
        .frame_ok_o  (frame_ok),
        .cmd_o       (cmd)
    );

    mw_irq_fifo #(.DEPTH(Q_DEPTH), .W(EVT_W), .CW(Q_CW)) u_fifo (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .push_i      (evt_push_i),
        .push_data_i (evt_word_i),
        .pop_i       (q_pop),
        .head_o      (q_head),
        .count_o     (q_count),
        .drop_o      (q_drop)
    );

    mw_reg_bank #(.REG_COUNT(REG_COUNT)) u_regs (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_en_i   (frame_ok && cmd.wr),
        .wr_addr_i (cmd.addr),
        .wr_data_i (cmd.data),
        .rd_addr_i (rd_ptr),
        .rd_data_o (rd_data)
    );

    assign reply = make_reply(q_count != '0, q_head, rd_ptr, rd_data);
    assign q_pop = frame_ok && sent_evt;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sent_evt   <= 1'b0;
            rd_ptr     <= '0;
            irq_q      <= 1'b0;
            ovf_q      <= 1'b0;
            stb_q      <= 1'b0;
            stb_addr_q <= '0;
            stb_data_q <= '0;
        end else begin
            if (load) sent_evt <= (q_count != '0);
            else if (frame_end) sent_evt <= 1'b0;
            if (frame_ok) rd_ptr <= cmd.addr;
            irq_q <= (q_count != '0) && !xfer_active;
            if (q_drop) ovf_q <= 1'b1;
            stb_q <= frame_ok && cmd.wr && addr_ok(cmd.addr, REG_COUNT);
            if (frame_ok) begin
                stb_addr_q <= cmd.addr;
                stb_data_q <= cmd.data;
            end
        end
    end

    assign sdo_oe_o   = !scs_n_i;
    assign irq_pull_o = irq_q;
    assign evt_ovf_o  = ovf_q;
    assign wr_stb_o   = stb_q;
    assign wr_addr_o  = stb_addr_q;
    assign wr_data_o  = stb_data_q;
endmodule

// File: rtl/mw_ctl_slave_chk.sv
module mw_ctl_slave_chk #(
    parameter int Q_DEPTH = 4,
    parameter int CW      = 3
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic          active,
    input logic          irq_pull,
    input logic          ovf,
    input logic          q_pop,
    input logic          frame_ok,
    input logic          wr_stb,
    input logic [CW-1:0] q_count
);
    AST_IRQ_OFF_IN_XFER: assert property (@(posedge clk_i) disable iff (rst_i)
        active |=> !irq_pull); // R7
    AST_IRQ_HAS_ENTRY: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_pull |-> q_count != '0); // R7
    AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
        ovf |=> ovf); // R8
    AST_QUEUE_BOUNDED: assert property (@(posedge clk_i) disable iff (rst_i)
        q_count <= CW'(Q_DEPTH)); // R8
    AST_POP_NONEMPTY: assert property (@(posedge clk_i) disable iff (rst_i)
        q_pop |-> q_count != '0); // R6
    AST_POP_ENDS_XFER: assert property (@(posedge clk_i) disable iff (rst_i)
        q_pop |=> !active); // R4
    AST_WR_AFTER_GOOD_FRAME: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_stb |-> $past(frame_ok)); // R1
endmodule

bind mw_ctl_slave mw_ctl_slave_chk #(.Q_DEPTH(Q_DEPTH), .CW(Q_CW)) chk_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .active   (xfer_active),
    .irq_pull (irq_pull_o),
    .ovf      (evt_ovf_o),
    .q_pop    (q_pop),
    .frame_ok (frame_ok),
    .wr_stb   (wr_stb_o),
    .q_count  (q_count)
);

// File: tb/mw_ctl_slave_tb_top.sv
module mw_ctl_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int NREG       = 16;
    localparam int QD         = 4;

    logic        clk = 1'b0, rst = 1'b1;
    logic        edge_sel = 1'b0, sclk = 1'b0, scs_n = 1'b1, sdi = 1'b0;
    logic        sdo, sdo_oe, evt_push = 1'b0, irq_pull, evt_ovf, wr_stb;
    logic [14:0] evt_word = '0;
    logic [6:0]  wr_addr;
    logic [7:0]  wr_data;

    int n_chk = 0, n_fail = 0;
    int wr_cnt = 0;
    logic [6:0] last_addr;
    logic [7:0] last_data;

    logic [7:0]  mreg [NREG];
    logic [14:0] mq [QD];
    int          mq_n = 0;
    logic [6:0]  mptr = '0;
    bit          movf = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mw_ctl_slave dut_i (
        .clk_i(clk), .rst_i(rst), .edge_sel_i(edge_sel), .sclk_i(sclk),
        .scs_n_i(scs_n), .sdi_i(sdi), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
        .evt_push_i(evt_push), .evt_word_i(evt_word), .irq_pull_o(irq_pull),
        .evt_ovf_o(evt_ovf), .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
    );

    always @(posedge clk) if (!rst && wr_stb) begin
        wr_cnt    <= wr_cnt + 1;
        last_addr <= wr_addr;
        last_data <= wr_data;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] exp_reply();
        if (mq_n > 0) return {1'b1, mq[0]};
        return {1'b0, mptr, (mptr < 7'(NREG)) ? mreg[mptr[3:0]] : 8'h00};
    endfunction

    task automatic xfer(input logic [15:0] word, input int nbits, input bit mode, output logic [15:0] got);
        edge_sel = mode; sclk = mode;
        wait_n(6);
        scs_n = 1'b0; sdi = word[15];
        wait_n(HALF);
        chk(sdo_oe == 1'b1, "R3 driver on in transfer", 32'(sdo_oe), 1);
        chk(irq_pull == 1'b0, "R7 request released in transfer", 32'(irq_pull), 0);
        got = '0;
        for (int i = 0; i < nbits; i++) begin
            if (i < 16) got[15-i] = sdo;
            sclk = ~mode;
            wait_n(HALF);
            sclk = mode;
            sdi = (i < 15) ? word[14-i] : 1'b0;
            wait_n(HALF);
        end
        scs_n = 1'b1;
        wait_n(1);
        chk(sdo_oe == 1'b0, "R3 driver off after select rises", 32'(sdo_oe), 0);
        wait_n(9);
    endtask

    task automatic run_valid(input bit wr, input logic [6:0] addr, input logic [7:0] data,
                             input bit mode, input string tag);
        logic [15:0] got, exp;
        int prev;
        exp  = exp_reply();
        prev = wr_cnt;
        xfer({wr, addr, data}, 16, mode, got);
        chk(got == exp, exp[15] ? {tag, " R6 event reply"} : {tag, " R5 readback reply"}, 32'(got), 32'(exp));
        if (mq_n > 0) begin
            for (int k = 0; k < QD - 1; k++) mq[k] = mq[k+1];
            mq_n--;
        end
        mptr = addr;
        if (wr && addr < 7'(NREG)) begin
            mreg[addr[3:0]] = data;
            chk(wr_cnt == prev + 1, "R1 write strobe count", 32'(wr_cnt), 32'(prev + 1));
            chk({last_addr, last_data} == {addr, data}, "R1 write strobe payload",
                32'({last_addr, last_data}), 32'({addr, data}));
        end else begin
            chk(wr_cnt == prev, "R1 R5 no strobe", 32'(wr_cnt), 32'(prev));
        end
        chk(irq_pull == (mq_n > 0), "R7 request after transfer", 32'(irq_pull), 32'(mq_n > 0));
    endtask

    task automatic run_abort(input int nbits, input bit mode);
        logic [15:0] got;
        int prev;
        prev = wr_cnt;
        xfer({1'b1, 7'(2 + $urandom_range(0, 5)), 8'($urandom())}, nbits, mode, got);
        chk(wr_cnt == prev, "R4 short or long transfer ignored", 32'(wr_cnt), 32'(prev));
        chk(irq_pull == (mq_n > 0), "R4 queue untouched", 32'(irq_pull), 32'(mq_n > 0));
    endtask

    task automatic push_evt(input logic [14:0] w);
        evt_word = w; evt_push = 1'b1;
        wait_n(1);
        evt_push = 1'b0;
        if (mq_n < QD) begin mq[mq_n] = w; mq_n++; end
        else movf = 1'b1;
        wait_n(4);
        chk(irq_pull == (mq_n > 0), "R7 request while queue holds events", 32'(irq_pull), 32'(mq_n > 0));
        chk(evt_ovf == movf, "R8 overflow flag", 32'(evt_ovf), 32'(movf));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd5412));
        for (int k = 0; k < NREG; k++) mreg[k] = 8'h00;
        wait_n(5);
        rst = 1'b0;
        wait_n(5);
        chk(sdo_oe == 1'b0, "R9 reset driver off", 32'(sdo_oe), 0);
        chk(irq_pull == 1'b0, "R9 reset request low", 32'(irq_pull), 0);
        chk(evt_ovf == 1'b0, "R9 reset overflow low", 32'(evt_ovf), 0);
        chk(wr_stb == 1'b0, "R9 reset strobe low", 32'(wr_stb), 0);
        run_valid(1'b0, 7'd3, 8'h00, 1'b0, "R9 first reply zero");

        run_valid(1'b1, 7'd5, 8'hA7, 1'b1, "R2 write falling capture");
        run_valid(1'b0, 7'd5, 8'h00, 1'b0, "R2 read rising capture");
        run_valid(1'b0, 7'd9, 8'h00, 1'b1, "R2 readback in falling mode");
        run_valid(1'b1, 7'd20, 8'h3C, 1'b0, "R5 out of range write");
        run_valid(1'b0, 7'd0, 8'h00, 1'b0, "R5 out of range read");

        run_abort(15, 1'b0);
        run_valid(1'b0, 7'd1, 8'h00, 1'b0, "R4 pointer kept after abort");
        for (int k = 0; k < 5; k++) push_evt(15'h1000 + 15'(k));
        run_abort(17, 1'b1);
        for (int k = 0; k < 4; k++) run_valid(1'b1, 7'(k), 8'(8'h50 + k), k[0], "R8 fifo order");
        chk(evt_ovf == 1'b1, "R8 overflow stays set", 32'(evt_ovf), 1);
        run_valid(1'b0, 7'd2, 8'h00, 1'b0, "R5 readback after drain");

        for (int it = 0; it < 70; it++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 2) push_evt(15'($urandom()));
            else if (op < 6) run_valid(1'b1, 7'($urandom_range(0, 23)), 8'($urandom()), 1'($urandom()), "R1 random write");
            else if (op < 8) run_valid(1'b0, 7'($urandom_range(0, 23)), 8'($urandom()), 1'($urandom()), "random read");
            else if (op == 8) run_abort(($urandom_range(0, 1) == 0) ? 8 : 17, 1'($urandom()));
            else wait_n(20);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule